// File: doc/BRIEF.md
# Masked Circular Buffer Address Generator

This block produces the write and read addresses of a first-in first-out queue whose storage is a window inside a larger memory. A base address and an address mask set the window at run time. Mask bits that are one select the fixed upper part of every address, and those bits come from the base. Mask bits that are zero carry a byte offset that moves through the window and wraps at its end. The window size is the inverse of the mask plus one. It must be a power of two and no smaller than 8 KiB.

Each push or pop request moves one memory word. The block keeps a write offset, a read offset and an occupancy count in bytes. It also reports full and empty flags. While the clear input is held, the queue stays empty, requests are ignored, and a new base and mask are taken from the configuration inputs. Releasing clear re-arms the queue with the new window. Moving data to and from the memory is handled by logic outside this block.

Top module: `masked_ring_addr_gen`

## Requirements
- R1: After reset the block reports empty=1, full=0 and fullness=0. The active base is 0, the active mask is the RESET_MASK parameter, and both addresses are 0.
- R2: Each emitted address takes the bits of the active base where the active mask is 1. It takes the bits of its pointer's byte offset where the mask is 0.
- R3: A push accepted while not full advances the write offset by WORD_BYTES (8 by default). It raises fullness by WORD_BYTES in the next cycle.
- R4: A pop accepted while not empty advances the read offset by WORD_BYTES. It lowers fullness by WORD_BYTES in the next cycle.
- R5: An offset that reaches the window size wraps to offset 0, so the address returns to the masked base.
- R6: Full is 1 exactly when fullness equals the window size (inverse of the mask plus one). A push alone while full is dropped: fullness and the write address do not change.
- R7: Empty is 1 exactly when fullness is 0. A pop alone while empty is ignored: fullness and the read address do not change.
- R8: When push and pop arrive in the same cycle, both are accepted if the queue is neither full nor empty, and fullness does not change. When full, only the pop is taken. When empty, only the push is taken.
- R9: While clear is 1, the next cycle shows fullness 0, empty 1 and both offsets at 0. Push and pop have no effect, and the base and mask are loaded from cfg_base and cfg_mask.
- R10: Changes on cfg_base or cfg_mask while clear is 0 have no effect on the emitted addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Empty the queue, hold it empty, and load the window |
| cfg_base | input | ADDR_W | Window base address, loaded while clear is 1 |
| cfg_mask | input | ADDR_W | Window mask (inverse of size minus one), loaded while clear is 1 |
| push | input | 1 | Store one word |
| pop | input | 1 | Remove one word |
| wr_addr | output | ADDR_W | Memory address of the next word written |
| rd_addr | output | ADDR_W | Memory address of the next word read |
| full | output | 1 | Occupancy equals the window size |
| empty | output | 1 | Occupancy is zero |
| fullness | output | ADDR_W+1 | Occupancy in bytes |

## Verification
Push and pop can land in the same cycle, and the hard cases are the edges: an empty queue, a full queue, and the moment a pointer wraps. The stimulus table issues simultaneous requests in the middle of the range and on an empty queue. A directed test fills the window completely and then issues push and pop together. Each case is judged against a bench model of the count and the two offsets. The expected outcome is that only the legal half of the pair takes effect, and that the offsets wrap at the window size.

// File: rtl/masked_ring_addr_gen.sv
module masked_ring_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int WORD_BYTES = 8,
  parameter logic [ADDR_W-1:0] RESET_MASK = ~ADDR_W'(8191)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W:0]   fullness
);

  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W:0]   STEP_C = (ADDR_W+1)'(WORD_BYTES);

  logic [ADDR_W-1:0] base_q, mask_q, wr_off, rd_off;
  logic [ADDR_W:0]   cnt, win;
  logic              do_push, do_pop;

  assign win      = {1'b0, ~mask_q} + (ADDR_W+1)'(1);
  assign full     = (cnt == win);
  assign empty    = (cnt == '0);
  assign fullness = cnt;
  assign do_push  = push && !full && !clear;
  assign do_pop   = pop && !empty && !clear;
  assign wr_addr  = (base_q & mask_q) | (wr_off & ~mask_q);
  assign rd_addr  = (base_q & mask_q) | (rd_off & ~mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= RESET_MASK;
      wr_off <= '0;
      rd_off <= '0;
      cnt    <= '0;
    end else if (clear) begin
      base_q <= cfg_base;
      mask_q <= cfg_mask;
      wr_off <= '0;
      rd_off <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_off <= (wr_off + STEP_A) & ~mask_q;
      if (do_pop)  rd_off <= (rd_off + STEP_A) & ~mask_q;
      if (do_push && !do_pop)      cnt <= cnt + STEP_C;
      else if (do_pop && !do_push) cnt <= cnt - STEP_C;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= win);
  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (empty && wr_addr == rd_addr));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clear) |=> ($stable(cnt) && $stable(wr_addr)));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clear) |=> ($stable(cnt) && $stable(rd_addr)));
  assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full && !clear) |=> (cnt == $past(cnt) + STEP_C));
  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty && !clear) |=> (cnt == $past(cnt) - STEP_C));
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ($stable(base_q) && $stable(mask_q)));

endmodule

// File: tb/masked_ring_addr_gen_tb.sv
module masked_ring_addr_gen_tb_top;
  localparam int AW = 32;
  localparam logic [AW-1:0] BASE = 32'h1234_7FF0;
  localparam logic [AW-1:0] MASK = ~32'h0000_1FFF;
  localparam int WIN = 8192;

  logic clk = 0, rst_n = 0, clear = 0, push = 0, pop = 0;
  logic [AW-1:0] cfg_base = '0, cfg_mask = '0;
  logic [AW-1:0] wr_addr, rd_addr;
  logic full, empty;
  logic [AW:0] fullness;

  int checks = 0, errors = 0;
  int m_cnt = 0, m_wr = 0, m_rd = 0, m_win = WIN;
  logic [AW-1:0] m_base = BASE, m_mask = MASK;

  always #5 clk = ~clk;

  masked_ring_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .push(push), .pop(pop), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .full(full), .empty(empty), .fullness(fullness));

  // each entry: push, pop, expected fullness after the cycle
  localparam int NV = 8;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'd8},  {1'b1, 1'b0, 32'd16}, {1'b1, 1'b1, 32'd16},
    {1'b0, 1'b1, 32'd8},  {1'b0, 1'b1, 32'd0},  {1'b0, 1'b1, 32'd0},
    {1'b1, 1'b1, 32'd8},  {1'b0, 1'b0, 32'd8}};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr_of(input int off);
    return (m_base & m_mask) | (AW'(off) & ~m_mask);
  endfunction

  task automatic step(input logic p, input logic q);
    bit ap, aq;
    ap = p && (m_cnt != m_win);
    aq = q && (m_cnt != 0);
    push = p; pop = q;
    @(posedge clk); @(negedge clk);
    push = 0; pop = 0;
    if (ap) begin m_wr = (m_wr + 8) % m_win; m_cnt += 8; end
    if (aq) begin m_rd = (m_rd + 8) % m_win; m_cnt -= 8; end
  endtask

  task automatic do_clear(input logic [AW-1:0] b, input logic [AW-1:0] m);
    cfg_base = b; cfg_mask = m; clear = 1;
    push = 1; pop = 1;
    @(posedge clk); @(negedge clk);
    clear = 0; push = 0; pop = 0;
    m_base = b; m_mask = m; m_win = int'(~m) + 1;
    m_cnt = 0; m_wr = 0; m_rd = 0;
  endtask

  task automatic chk_state(input string req);
    chk({req, " fullness"}, fullness, m_cnt);
    chk({req, " wr_addr"}, wr_addr, addr_of(m_wr));
    chk({req, " rd_addr"}, rd_addr, addr_of(m_rd));
    chk({req, " full"}, full, m_cnt == m_win);
    chk({req, " empty"}, empty, m_cnt == 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 fullness", fullness, 0);
    chk("R1 wr_addr", wr_addr, 0);
    chk("R1 rd_addr", rd_addr, 0);

    // R9 clear loads window and ignores requests
    do_clear(BASE, MASK);
    chk_state("R9 after clear");
    chk("R2 masked base", wr_addr, 32'h1234_6000);

    // R3 R4 R7 R8 table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][33], VEC[i][32]);
      chk("R8 table fullness", fullness, VEC[i][31:0]);
      chk_state("R2 R3 R4 table");
    end

    // R10 config changes outside clear are ignored
    cfg_base = 32'hFFFF_FFFF; cfg_mask = 32'hFFFF_0000;
    step(0, 0);
    chk_state("R10 cfg ignored");

    // R5 R6 fill to full, write offset wraps
    while (m_cnt < WIN) step(1, 0);
    chk("R6 full", full, 1);
    chk("R6 fullness", fullness, WIN);
    chk_state("R5 wrap at fill");
    step(1, 0);
    chk_state("R6 push dropped");
    step(1, 1);
    chk("R8 full pair", fullness, WIN - 8);
    chk_state("R8 full pair state");

    // R5 drain, read offset wraps
    while (m_cnt > 0) step(0, 1);
    chk_state("R5 R7 drained");
    step(0, 1);
    chk_state("R7 pop ignored");

    // R9 clear while holding data, new larger window
    step(1, 0); step(1, 0);
    do_clear(32'hABCD_0000, ~32'h0000_3FFF);
    chk_state("R9 reclear");
    for (int k = 0; k < 1024; k++) step(1, 0);
    chk("R6 larger window not full", full, 0);
    chk_state("R2 larger window");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule